// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Burst Column Sequencer

This block sits on the controller side of a double-data-rate SDRAM and follows what the device does with each registered command. It keeps the mode register and records which banks hold an open row, along with the row latched for each bank. For every accepted read or write it walks the burst: each clock cycle it presents the pair of column addresses that one two-word internal access covers. The pairs come out in sequential or interleaved order. A read also gets a data-valid window that starts after the programmed CAS latency.

Commands arrive on a three-bit code with a bank address and a thirteen-bit address, and the block samples them on every rising clock edge. A command that breaks the device rules has no effect on state. The block reports it with a single-cycle error pulse, one per error class. Auto-precharge closes the burst's bank by itself at the edge that ends the last beat. A command at that same edge already sees the bank as closed.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is low and after it, every bank reads closed, no beat or read-valid or error is shown, and the mode register reads 0x021 (burst length 2, sequential, CAS latency 2).
- R2: Command code 4 with bank address 0, on an idle device and with legal fields, loads the whole address into the mode register: bits [2:0] burst length, bit 3 order (0 sequential, 1 interleaved), bits [6:4] CAS latency. Code 4 with a non-zero bank address changes nothing and raises no flag.
- R3: Mode bit 8 reads 1 for the single cycle after a load that sets it, and then reads 0.
- R4: A mode load whose length code is not 001 (2), 010 (4) or 011 (8), or whose latency code is not 010 (2) or 011 (3), pulses err_mode_o and leaves the register unchanged.
- R5: A mode load while any bank is open, or while a burst has beats left after the current one, pulses err_mrs_o and leaves the register unchanged.
- R6: Command code 1 opens the addressed bank and latches the address as its row, which col_row_o shows during that bank's bursts. Code 1 to a bank that is already open pulses err_cmd_o and changes nothing.
- R7: A read (code 2) or write (code 3) to a closed bank, or issued while the current burst has beats left, pulses err_cmd_o and starts nothing. Codes 6 and 7 also pulse err_cmd_o.
- R8: An accepted read or write with length N shows col_valid_o for N/2 consecutive cycles, starting the cycle after the command. Beat k shows locations 2k on col_lo_o and 2k+1 on col_hi_o. A new burst issued at the edge that ends the last beat follows without a gap.
- R9: In sequential order, location i has low log2(N) column bits equal to (start + i) mod N. The upper bits stay those of the start column.
- R10: In interleaved order, location i has low bits equal to the start low bits XOR i.
- R11: Address bit 10 on a read or write requests auto-precharge. The bank closes at the edge that ends the last beat, and a command at that edge treats the bank as closed.
- R12: rd_valid_o rises exactly CAS-latency cycles after the edge that accepts a read and stays high for N/2 cycles. Writes never raise it.
- R13: Command code 5 closes the addressed bank, or every bank when address bit 10 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command code: 0 none, 1 activate, 2 read, 3 write, 4 mode load, 5 precharge |
| ba_i | input | BA_W | Bank address |
| addr_i | input | AW | Row, column or mode value; bit 10 selects auto-precharge or all banks |
| mode_o | output | AW | Current mode register |
| bank_open_o | output | 2**BA_W | One bit per bank, set while the bank has an open row |
| col_valid_o | output | 1 | A burst beat is shown this cycle |
| col_lo_o | output | CW | Column of the even location of the beat |
| col_hi_o | output | CW | Column of the odd location of the beat |
| col_bank_o | output | BA_W | Bank of the burst |
| col_row_o | output | AW | Row latched for the burst's bank |
| col_write_o | output | 1 | The burst is a write |
| rd_valid_o | output | 1 | Read data is valid this cycle |
| err_cmd_o | output | 1 | Pulse: illegal activate, read, write or command code |
| err_mrs_o | output | 1 | Pulse: mode load while the device is busy |
| err_mode_o | output | 1 | Pulse: mode load with an unsupported length or latency |

## Verification
The case that matters is the end of an auto-precharge burst meeting a new command on the same edge. The bank that is closing must look closed to that command: an activate to it must succeed, and a read to it must be refused. The bench starts an auto-precharge read and then a seamless auto-precharge write. It issues an activate at the write's final edge and, in a later burst, a read at the final edge. A per-cycle reference model decides the legality of each command from the bank state as it stands after the pending close. A second collision comes from a short burst with a long latency: the next read's burst overlaps the previous read's data window. The model keeps each read's window on its own schedule.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_MRS  = 3'd4,
    OP_PRE  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } ddr_op_e;

  // mode register field positions
  localparam int MF_BL_LSB = 0;
  localparam int MF_ORDER  = 3;
  localparam int MF_CL_LSB = 4;
  localparam int MF_SELFCLR = 8;
  localparam int AP_BIT    = 10;

  // burst length in locations from the 3-bit code, 0 when unsupported
  function automatic logic [3:0] burst_len(input logic [2:0] code);
    case (code)
      3'b001:  return 4'd2;
      3'b010:  return 4'd4;
      3'b011:  return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  // CAS latency in cycles from the 3-bit code, 0 when unsupported
  function automatic logic [1:0] cas_cycles(input logic [2:0] code);
    case (code)
      3'b010:  return 2'd2;
      3'b011:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic mode_fields_ok(input logic [2:0] bl_code, input logic [2:0] cl_code);
    return (burst_len(bl_code) != 4'd0) && (cas_cycles(cl_code) != 2'd0);
  endfunction

endpackage

// File: rtl/ddr_mode_reg.sv
module ddr_mode_reg
  import ddr_seq_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mrs_req,
  input  logic          dev_busy,
  input  logic [AW-1:0] mrs_val,
  output logic [AW-1:0] mode_q,
  output logic          err_mrs_q,
  output logic          err_mode_q
);

  localparam logic [AW-1:0] MODE_RESET = AW'(7'h21);
  localparam logic [AW-1:0] SELF_MASK  = AW'(1) << MF_SELFCLR;

  logic fields_ok;
  logic mrs_accept;

  assign fields_ok  = mode_fields_ok(mrs_val[MF_BL_LSB +: 3], mrs_val[MF_CL_LSB +: 3]);
  assign mrs_accept = mrs_req && !dev_busy && fields_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_RESET;
      err_mrs_q  <= 1'b0;
      err_mode_q <= 1'b0;
    end else begin
      err_mrs_q  <= mrs_req && dev_busy;
      err_mode_q <= mrs_req && !dev_busy && !fields_ok;
      if (mrs_accept) mode_q <= mrs_val;
      else            mode_q[MF_SELFCLR] <= 1'b0;
    end
  end

  // R3: the self-clearing bit never holds for two cycles
  a_r3_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[MF_SELFCLR] |=> !mode_q[MF_SELFCLR]);

  // R4: a rejected illegal load keeps the stored fields
  a_r4_illegal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode_q |-> ((mode_q & ~SELF_MASK) == ($past(mode_q) & ~SELF_MASK)));

  // R5: a load while busy keeps the stored fields
  a_r5_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    err_mrs_q |-> ((mode_q & ~SELF_MASK) == ($past(mode_q) & ~SELF_MASK)));

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
  parameter int BA_W = 2,
  parameter int AW   = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_req,
  input  logic [BA_W-1:0] act_bank,
  input  logic [AW-1:0]   act_row,
  input  logic            pre_req,
  input  logic            pre_all,
  input  logic [BA_W-1:0] pre_bank,
  input  logic            ap_close,
  input  logic [BA_W-1:0] ap_bank,
  input  logic [BA_W-1:0] sel_bank,
  output logic [(1<<BA_W)-1:0] open_q,
  output logic [(1<<BA_W)-1:0] eff_open,
  output logic [AW-1:0]   sel_row
);

  localparam int NB = 1 << BA_W;

  logic [AW-1:0]  row_q [NB];
  logic [NB-1:0]  ap_mask;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit_act, hit_pre, hit_ap;
    assign hit_act    = act_req && (act_bank == BA_W'(b));
    assign hit_pre    = pre_req && (pre_all || (pre_bank == BA_W'(b)));
    assign hit_ap     = ap_close && (ap_bank == BA_W'(b));
    assign ap_mask[b] = hit_ap;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else begin
        if (hit_act)                open_q[b] <= 1'b1;
        else if (hit_pre || hit_ap) open_q[b] <= 1'b0;
        if (hit_act) row_q[b] <= act_row;
      end
    end
  end

  assign eff_open = open_q & ~ap_mask;
  assign sel_row  = row_q[sel_bank];

  // R6: an accepted activate leaves its bank open
  a_r6_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    act_req |=> open_q[$past(act_bank)]);

  // R11: auto-precharge closes the bank unless it is reopened at that edge
  a_r11_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_close && !(act_req && act_bank == ap_bank)) |=> !open_q[$past(ap_bank)]);

endmodule

// File: rtl/ddr_burst_gen.sv
module ddr_burst_gen
  import ddr_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int CW     = 10,
  parameter int MAX_CL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_wr,
  input  logic            start_ap,
  input  logic [BA_W-1:0] start_bank,
  input  logic [CW-1:0]   start_col,
  input  logic [2:0]      bl_code,
  input  logic            order_il,
  input  logic [2:0]      cl_code,
  output logic            col_valid,
  output logic [CW-1:0]   col_lo,
  output logic [CW-1:0]   col_hi,
  output logic [BA_W-1:0] col_bank,
  output logic            col_write,
  output logic            cont,
  output logic            ap_close,
  output logic [BA_W-1:0] ap_bank,
  output logic            rd_valid
);

  localparam int BEAT_W = 3;

  // column of location loc inside a burst of n locations
  function automatic logic [CW-1:0] col_of(input logic [CW-1:0] s, input logic [2:0] loc,
                                           input logic [3:0] n, input logic il);
    logic [CW-1:0] mask, low;
    mask = CW'(n) - CW'(1);
    low  = il ? ((s ^ CW'(loc)) & mask) : ((s + CW'(loc)) & mask);
    return (s & ~mask) | low;
  endfunction

  logic [BEAT_W-1:0] beat_q, nbeat_q;
  logic [CW-1:0]     scol_q;
  logic [3:0]        blen_q;
  logic              il_q, ap_q, last;
  logic [3:0]        new_len;

  assign new_len = burst_len(bl_code);
  assign last    = col_valid && (beat_q == nbeat_q - BEAT_W'(1));
  assign cont    = col_valid && !last;
  assign ap_close = last && ap_q;
  assign ap_bank  = col_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      beat_q    <= '0;
      nbeat_q   <= BEAT_W'(1);
      scol_q    <= '0;
      blen_q    <= 4'd2;
      il_q      <= 1'b0;
      ap_q      <= 1'b0;
      col_bank  <= '0;
      col_write <= 1'b0;
    end else if (start) begin
      col_valid <= 1'b1;
      beat_q    <= '0;
      nbeat_q   <= BEAT_W'(new_len >> 1);
      scol_q    <= start_col;
      blen_q    <= new_len;
      il_q      <= order_il;
      ap_q      <= start_ap;
      col_bank  <= start_bank;
      col_write <= start_wr;
    end else if (col_valid) begin
      if (last) col_valid <= 1'b0;
      else      beat_q    <= beat_q + BEAT_W'(1);
    end
  end

  assign col_lo = col_of(scol_q, {beat_q[1:0], 1'b0}, blen_q, il_q);
  assign col_hi = col_of(scol_q, {beat_q[1:0], 1'b1}, blen_q, il_q);

  // read-valid scheduling: each launched read travels down a delay line
  logic              rd_launch;
  logic [MAX_CL:1]   dly_q;
  logic [2:0]        dly_len_q [MAX_CL:1];
  logic [2:0]        rd_cnt_q;
  logic [1:0]        lat;

  assign rd_launch = start && !start_wr;
  assign lat       = cas_cycles(cl_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q    <= '0;
      rd_cnt_q <= '0;
      for (int i = 1; i <= MAX_CL; i++) dly_len_q[i] <= '0;
    end else begin
      for (int i = 1; i < MAX_CL; i++) begin
        dly_q[i]     <= dly_q[i+1];
        dly_len_q[i] <= dly_len_q[i+1];
      end
      dly_q[MAX_CL]     <= 1'b0;
      dly_len_q[MAX_CL] <= '0;
      if (rd_launch && lat != 2'd0) begin
        dly_q[int'(lat)]     <= 1'b1;
        dly_len_q[int'(lat)] <= new_len[3:1];
      end
      if (dly_q[1])                rd_cnt_q <= dly_len_q[1];
      else if (rd_cnt_q != 3'd0)   rd_cnt_q <= rd_cnt_q - 3'd1;
    end
  end

  assign rd_valid = (rd_cnt_q != 3'd0);

  // R8: the two columns of a beat differ only inside the burst block, in bit 0
  a_r8_pair_local: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> (((col_lo ^ col_hi) < CW'(blen_q)) && (col_lo[0] != col_hi[0])));

  // R12: a data window opens only two or three cycles after an accepted read
  a_r12_rise_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> ($past(rd_launch, 3) || $past(rd_launch, 4)));

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int BA_W = 2,
  parameter int AW   = 13,
  parameter int CW   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [AW-1:0]        addr_i,
  output logic [AW-1:0]        mode_o,
  output logic [(1<<BA_W)-1:0] bank_open_o,
  output logic                 col_valid_o,
  output logic [CW-1:0]        col_lo_o,
  output logic [CW-1:0]        col_hi_o,
  output logic [BA_W-1:0]      col_bank_o,
  output logic [AW-1:0]        col_row_o,
  output logic                 col_write_o,
  output logic                 rd_valid_o,
  output logic                 err_cmd_o,
  output logic                 err_mrs_o,
  output logic                 err_mode_o
);

  localparam int NB = 1 << BA_W;
  localparam logic [AW-1:0] SELF_MASK = AW'(1) << MF_SELFCLR;

  ddr_op_e        op;
  logic [NB-1:0]  eff_open;
  logic           burst_cont, ap_close;
  logic [BA_W-1:0] ap_bank;
  logic           bank_ok, is_rw, dev_busy;
  logic           act_req, rw_req, mrs_req, pre_req, err_cmd_d;

  assign op       = ddr_op_e'(cmd_i);
  assign bank_ok  = eff_open[ba_i];
  assign is_rw    = (op == OP_RD) || (op == OP_WR);
  assign dev_busy = (|eff_open) || burst_cont;

  assign act_req  = (op == OP_ACT) && !bank_ok;
  assign rw_req   = is_rw && bank_ok && !burst_cont;
  assign mrs_req  = (op == OP_MRS) && (ba_i == '0);
  assign pre_req  = (op == OP_PRE);
  assign err_cmd_d = ((op == OP_ACT) && bank_ok) ||
                     (is_rw && !rw_req) ||
                     (op == OP_RSV6) || (op == OP_RSV7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_cmd_o <= 1'b0;
    else        err_cmd_o <= err_cmd_d;
  end

  ddr_mode_reg #(.AW(AW)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mrs_req    (mrs_req),
    .dev_busy   (dev_busy),
    .mrs_val    (addr_i),
    .mode_q     (mode_o),
    .err_mrs_q  (err_mrs_o),
    .err_mode_q (err_mode_o)
  );

  ddr_bank_tracker #(.BA_W(BA_W), .AW(AW)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_req  (act_req),
    .act_bank (ba_i),
    .act_row  (addr_i),
    .pre_req  (pre_req),
    .pre_all  (addr_i[AP_BIT]),
    .pre_bank (ba_i),
    .ap_close (ap_close),
    .ap_bank  (ap_bank),
    .sel_bank (col_bank_o),
    .open_q   (bank_open_o),
    .eff_open (eff_open),
    .sel_row  (col_row_o)
  );

  ddr_burst_gen #(.BA_W(BA_W), .CW(CW), .MAX_CL(3)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rw_req),
    .start_wr   (op == OP_WR),
    .start_ap   (addr_i[AP_BIT]),
    .start_bank (ba_i),
    .start_col  (addr_i[CW-1:0]),
    .bl_code    (mode_o[MF_BL_LSB +: 3]),
    .order_il   (mode_o[MF_ORDER]),
    .cl_code    (mode_o[MF_CL_LSB +: 3]),
    .col_valid  (col_valid_o),
    .col_lo     (col_lo_o),
    .col_hi     (col_hi_o),
    .col_bank   (col_bank_o),
    .col_write  (col_write_o),
    .cont       (burst_cont),
    .ap_close   (ap_close),
    .ap_bank    (ap_bank),
    .rd_valid   (rd_valid_o)
  );

  // R2: a mode load to a non-zero bank address leaves the stored fields alone
  a_r2_ba_filter: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_MRS) && (ba_i != '0)) |=> ((mode_o & ~SELF_MASK) == ($past(mode_o) & ~SELF_MASK)));

  // R7: no burst begins right after a refused read or write
  a_r7_refused_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && !burst_cont && !bank_ok) |=> !(col_valid_o && $past(!col_valid_o)));

endmodule

// File: tb/ddr_cmd_seq_tb.sv
`timescale 1ns/1ps
module ddr_cmd_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  ba = 2'd0;
  logic [12:0] addr = 13'd0;

  logic [12:0] mode_o, col_row_o;
  logic [3:0]  bank_open_o;
  logic        col_valid_o, col_write_o, rd_valid_o, err_cmd_o, err_mrs_o, err_mode_o;
  logic [9:0]  col_lo_o, col_hi_o;
  logic [1:0]  col_bank_o;

  always #10 clk = ~clk;

  ddr_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .ba_i(ba), .addr_i(addr),
    .mode_o(mode_o), .bank_open_o(bank_open_o), .col_valid_o(col_valid_o),
    .col_lo_o(col_lo_o), .col_hi_o(col_hi_o), .col_bank_o(col_bank_o),
    .col_row_o(col_row_o), .col_write_o(col_write_o), .rd_valid_o(rd_valid_o),
    .err_cmd_o(err_cmd_o), .err_mrs_o(err_mrs_o), .err_mode_o(err_mode_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference model state
  int          cyc = 0;
  logic [12:0] m_mode = 13'h021;
  logic [3:0]  m_open = 4'b0;
  logic [12:0] m_row [4] = '{default: 13'd0};
  int          q_lo[$], q_hi[$];
  int          cur_bank = 0, cur_wr = 0, cur_ap = 0, cur_il = 0;
  bit          rd_sched [int];
  bit          e_cmd = 0, e_mrs = 0, e_md = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit legal_mode(input logic [12:0] v);
    bit bl_ok, cl_ok;
    bl_ok = (v[2:0] >= 3'd1) && (v[2:0] <= 3'd3);
    cl_ok = (v[6:4] == 3'd2) || (v[6:4] == 3'd3);
    return bl_ok && cl_ok;
  endfunction

  task automatic model_edge();
    bit apc, cont, any_open, mrs_ok;
    logic [3:0] eo;
    cyc++;
    apc  = (q_lo.size() == 1) && (cur_ap != 0);
    cont = (q_lo.size() > 1);
    eo = m_open;
    if (apc) eo[cur_bank] = 1'b0;
    any_open = (eo != 4'b0);
    if (q_lo.size() > 0) begin
      void'(q_lo.pop_front());
      void'(q_hi.pop_front());
    end
    if (apc) m_open[cur_bank] = 1'b0;
    e_cmd = 0; e_mrs = 0; e_md = 0; mrs_ok = 0;
    case (cmd)
      3'd1: begin
        if (eo[ba]) e_cmd = 1;
        else begin m_open[ba] = 1'b1; m_row[ba] = addr; end
      end
      3'd2, 3'd3: begin
        if (!eo[ba] || cont) e_cmd = 1;
        else begin
          int n, s, base;
          n = 1 << m_mode[2:0];
          s = int'(addr[9:0]);
          base = s - (s % n);
          cur_il = m_mode[3];
          for (int loc = 0; loc < n; loc++) begin
            int low;
            low = cur_il ? ((s % n) ^ loc) : ((s + loc) % n);
            if (loc % 2 == 0) q_lo.push_back(base + low);
            else              q_hi.push_back(base + low);
          end
          cur_bank = ba; cur_wr = (cmd == 3'd3); cur_ap = addr[10];
          if (cmd == 3'd2)
            for (int k = 0; k < n / 2; k++) rd_sched[cyc + int'(m_mode[6:4]) + k] = 1;
        end
      end
      3'd4: begin
        if (ba == 2'd0) begin
          if (any_open || cont) e_mrs = 1;
          else if (!legal_mode(addr)) e_md = 1;
          else begin m_mode = addr; mrs_ok = 1; end
        end
      end
      3'd5: begin
        if (addr[10]) m_open = 4'b0;
        else          m_open[ba] = 1'b0;
      end
      3'd6, 3'd7: e_cmd = 1;
      default: ;
    endcase
    if (!mrs_ok) m_mode[8] = 1'b0;
  endtask

  task automatic compare();
    string ord;
    chk("R6/R11/R13", "bank_open", 32'(bank_open_o), 32'(m_open));
    chk("R2/R3", "mode", 32'(mode_o), 32'(m_mode));
    chk("R8", "col_valid", 32'(col_valid_o), 32'(q_lo.size() > 0));
    if (q_lo.size() > 0) begin
      ord = cur_il ? "R10" : "R9";
      chk(ord, "col_lo", 32'(col_lo_o), 32'(q_lo[0]));
      chk(ord, "col_hi", 32'(col_hi_o), 32'(q_hi[0]));
      chk("R8", "col_bank", 32'(col_bank_o), 32'(cur_bank));
      chk("R8", "col_write", 32'(col_write_o), 32'(cur_wr));
      chk("R6", "col_row", 32'(col_row_o), 32'(m_row[cur_bank]));
    end
    chk("R12", "rd_valid", 32'(rd_valid_o), 32'(rd_sched.exists(cyc)));
    chk("R7", "err_cmd", 32'(err_cmd_o), 32'(e_cmd));
    chk("R5", "err_mrs", 32'(err_mrs_o), 32'(e_mrs));
    chk("R4", "err_mode", 32'(err_mode_o), 32'(e_md));
  endtask

  task automatic step(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a);
    cmd = c; ba = b; addr = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(3'd0, 2'd0, 13'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset bank_open", 32'(bank_open_o), 32'h0);
    chk("R1", "reset mode", 32'(mode_o), 32'h021);
    chk("R1", "reset col_valid", 32'(col_valid_o), 32'h0);
    chk("R1", "reset rd_valid", 32'(rd_valid_o), 32'h0);
    chk("R1", "reset errors", 32'({err_cmd_o, err_mrs_o, err_mode_o}), 32'h0);
    rst_n = 1'b1;

    step(3'd4, 2'd1, 13'h032);          // R2: non-zero bank address ignored
    step(3'd4, 2'd0, 13'h132);          // R2/R3: BL4 seq CL3 with self-clearing bit
    nop(1);
    step(3'd4, 2'd0, 13'h035);          // R4: bad length code
    step(3'd4, 2'd0, 13'h042);          // R4: bad latency code
    step(3'd1, 2'd1, 13'h1ABC);         // R6
    step(3'd1, 2'd1, 13'h0001);         // R6: already open
    step(3'd4, 2'd0, 13'h021);          // R5: bank open
    step(3'd2, 2'd1, 13'h005);          // R8/R9: read BL4 from column 5
    step(3'd2, 2'd1, 13'h004);          // R7: burst still running
    step(3'd2, 2'd2, 13'h000);          // R7: closed bank
    nop(5);
    step(3'd3, 2'd1, 13'h00E);          // R8: write, no rd_valid
    nop(3);
    step(3'd7, 2'd0, 13'h000);          // R7: reserved code
    step(3'd5, 2'd0, 13'h400);          // R13: close all
    step(3'd4, 2'd0, 13'h02B);          // R2: BL8 interleaved CL2
    step(3'd1, 2'd0, 13'h0123);
    step(3'd1, 2'd3, 13'h1F00);
    step(3'd2, 2'd0, 13'h7F6);          // R10/R11: interleaved read with auto-precharge
    nop(3);
    step(3'd3, 2'd3, 13'h409);          // R8/R11: seamless write at closing edge
    step(3'd2, 2'd0, 13'h000);          // R7/R11: bank 0 already closed
    nop(2);
    step(3'd1, 2'd3, 13'h0777);         // R11: activate at the write's closing edge
    nop(4);
    step(3'd5, 2'd3, 13'h000);          // R13: single bank
    step(3'd1, 2'd2, 13'h0005);
    step(3'd2, 2'd2, 13'h400);          // R11
    nop(3);
    step(3'd2, 2'd2, 13'h000);          // R11: read at the closing edge is refused
    nop(6);
    step(3'd4, 2'd0, 13'h031);          // BL2 seq CL3
    step(3'd1, 2'd0, 13'h0010);
    step(3'd2, 2'd0, 13'h003);          // R9: wrap inside the pair
    step(3'd2, 2'd0, 13'h002);          // R8: seamless BL2
    step(3'd3, 2'd0, 13'h001);
    step(3'd2, 2'd0, 13'h404);          // R11
    nop(6);
    step(3'd4, 2'd0, 13'h021);          // BL2 seq CL2
    step(3'd1, 2'd1, 13'h0ABC);
    step(3'd2, 2'd1, 13'h007);          // R12: CL2
    step(3'd2, 2'd1, 13'h006);
    nop(5);
    step(3'd5, 2'd1, 13'h000);          // R13
    step(3'd4, 2'd0, 13'h012);          // R4: latency code 1
    nop(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule